// File: doc/BRIEF.md
# Three-Phase Gate Drive Protection Controller

This block sits between six PWM commands and the six gate-enable lines of a three-leg half-bridge power stage. Each leg has its own interlock. A command is passed to its gate only if it rose while the opposite command of that leg was low. When one gate of a leg turns off, a dead-time window must pass before any gate of that leg may turn on again. A per-leg high-side supply flag with hysteresis keeps the high gate of that leg off while its floating supply is low.

A filter qualifies the digital over-current comparator flag by counting consecutive high samples. A qualified trip removes all six gates at once and holds the active-low fault line for a fixed clear time. Normal operation then resumes, but only once the over-current flag has gone low. A falling-supply flag on the main logic supply also removes all gates and asserts the fault line. The fault persists until the rising-supply flag is seen, which gives hysteresis. After any fault, a command that is still held must be released and asserted again before it reaches its gate. All durations are parameters counted in clock cycles, and all flags are synchronous to `clk`.

The supervisor state machine has four states:
- `SV_UNDERV`: supply not yet good. This is the reset state, and the fault line is low.
- `SV_RUN`: gates enabled and the fault line high.
- `SV_CLEAR`: the clear timer is running.
- `SV_HOLD`: the timer has expired but the over-current flag is still high.

Its transitions are:
- supply-rise: `SV_UNDERV` to `SV_RUN`.
- trip: `SV_RUN` to `SV_CLEAR`.
- expire-clean: `SV_CLEAR` to `SV_RUN`.
- expire-busy: `SV_CLEAR` to `SV_HOLD`.
- oc-release: `SV_HOLD` to `SV_RUN`.
- supply-fall: any state to `SV_UNDERV`. This transition has priority over the others.

Each leg state machine has four states:
- `LG_IDLE`: both gates off.
- `LG_HIGH`: high gate on.
- `LG_LOW`: low gate on.
- `LG_DEAD`: both gates off while the dead-time counter runs.

Its transitions are:
- grant-high and grant-low: `LG_IDLE` to `LG_HIGH` or `LG_LOW`.
- release: `LG_HIGH` or `LG_LOW` to `LG_DEAD`, when the command drops, the block is disabled, or the high-side supply is lost.
- dead-done: `LG_DEAD` to `LG_IDLE` after `DEAD_CYC` cycles.

Top module: `gate_guard`

## Requirements
- R1: Within a leg, `gate_hi[i]` and `gate_lo[i]` are never high in the same cycle.
- R2: In `SV_RUN`, with the leg idle and the high-side supply good, consider a command that rises while the opposite command of its leg is low. Its gate goes high two clock edges after the command is first sampled high. The gate goes low one edge after the command is first sampled low.
- R3: A command that rises while the opposite command of its leg is high never reaches its gate. This holds even after the first command drops, until it is released and asserted again while the opposite command is low.
- R4: If both commands of a leg rise in the same cycle, neither gate turns on.
- R5: After a gate of a leg turns off, both gates of that leg stay off for at least `DEAD_CYC` cycles. Suppose the high command falls and the low command rises in the same cycle. The low gate then turns on `DEAD_CYC`+2 edges after the change is sampled.
- R6: If `oc_flag` is high for fewer than `FILT_CYC` consecutive samples, the gates and the fault line are unaffected.
- R7: If `oc_flag` is high for `FILT_CYC` consecutive samples, all six gates go low and `fault_n` goes low right after the last of those edges. The filter window is capped at `SHUT_CYC`, so shutdown never takes longer than `SHUT_CYC` samples.
- R8: After a trip, `fault_n` stays low and all gates stay off for exactly `CLEAR_CYC` cycles. `fault_n` then returns high if `oc_flag` is low at expiry.
- R9: If `oc_flag` is still high when the clear time expires, the fault persists. The block resumes one edge after `oc_flag` is sampled low.
- R10: When `fault_n` returns high, all gates are off. A command held through the fault must fall and rise again before it drives its gate.
- R11: A pulse on `vdd_low_fall` drives all gates off and `fault_n` low on the next edge. They stay that way after the pulse ends, until a `vdd_ok_rise` pulse returns `fault_n` high on the following edge.
- R12: For leg i, a `hs_low_fall[i]` pulse forces `gate_hi[i]` off from the next edge until a `hs_ok_rise[i]` pulse is seen. `gate_lo[i]` is unaffected. Each supply flag is latched, and the falling flag wins when both are present.
- R13: While `rst_n` is low, and after release until `vdd_ok_rise` is seen, all gates are off and `fault_n` is low. Each high-side supply starts in the not-good state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_hi | input | NLEG | High-side commands, one bit per leg |
| pwm_lo | input | NLEG | Low-side commands, one bit per leg |
| oc_flag | input | 1 | Raw over-current comparator flag |
| vdd_ok_rise | input | 1 | Logic supply crossed its rising threshold |
| vdd_low_fall | input | 1 | Logic supply crossed its falling threshold |
| hs_ok_rise | input | NLEG | Per-leg high-side supply crossed its rising threshold |
| hs_low_fall | input | NLEG | Per-leg high-side supply crossed its falling threshold |
| gate_hi | output | NLEG | High-side gate enables |
| gate_lo | output | NLEG | Low-side gate enables |
| fault_n | output | 1 | Active-low fault indication |

## Verification
Most internal faults surface at the gate pins within one or two edges.
- An arm bit set when it should not be shows up as a gate that turns on against R3 or R10. The bench observes this on the grant edge, two edges after the command changes.
- A dead-time counter that ends early moves the complementary turn-on earlier than `DEAD_CYC`+2 edges.
- A filter or clear counter that is off by one moves the edge at which `fault_n` falls or rises by exactly one cycle. The bench therefore checks both sides of each such boundary.
- A supervisor that is stuck in the wrong state shows up as `fault_n` disagreeing with the expected value on the very next sample.

// File: rtl/gd_pkg.sv
package gd_pkg;

    // Per-leg interlock states
    typedef enum logic [1:0] {
        LG_IDLE = 2'd0,
        LG_HIGH = 2'd1,
        LG_LOW  = 2'd2,
        LG_DEAD = 2'd3
    } leg_state_e;

    // Fault supervisor states
    typedef enum logic [1:0] {
        SV_UNDERV = 2'd0,
        SV_RUN    = 2'd1,
        SV_CLEAR  = 2'd2,
        SV_HOLD   = 2'd3
    } sup_state_e;

endpackage

// File: rtl/gd_oc_filter.sv
// Qualifies the over-current flag: trip is raised on the FILT_CYC-th
// consecutive high sample and stays up while the flag stays high.
module gd_oc_filter #(
    parameter int FILT_CYC = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic oc_raw,
    output logic trip
);
    localparam int CW = $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] CNT_TOP = CW'(FILT_CYC - 1);

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (!oc_raw) begin
            run_cnt <= '0;
        end else if (run_cnt != CNT_TOP) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    always_comb begin
        trip = oc_raw && (run_cnt == CNT_TOP);
    end

endmodule

// File: rtl/gd_supervisor.sv
// Fault supervisor: supply hysteresis, trip handling, timed clear.
module gd_supervisor
    import gd_pkg::*;
#(
    parameter int CLEAR_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    input  logic oc_raw,
    input  logic vdd_rise,
    input  logic vdd_fall,
    output logic run,
    output logic fault_n
);
    localparam int TW = $clog2(CLEAR_CYC + 1);
    localparam logic [TW-1:0] TMR_LAST = TW'(CLEAR_CYC - 1);

    sup_state_e    st, st_nx;
    logic [TW-1:0] tmr;

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            SV_UNDERV: if (vdd_rise)          st_nx = SV_RUN;
            SV_RUN:    if (trip)              st_nx = SV_CLEAR;
            SV_CLEAR:  if (tmr == TMR_LAST)   st_nx = oc_raw ? SV_HOLD : SV_RUN;
            SV_HOLD:   if (!oc_raw)           st_nx = SV_RUN;
        endcase
        if (vdd_fall) begin
            st_nx = SV_UNDERV;
        end
    end

    // state register and clear timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= SV_UNDERV;
            tmr <= '0;
        end else begin
            st  <= st_nx;
            tmr <= (st == SV_CLEAR && st_nx == SV_CLEAR) ? tmr + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        run     = (st == SV_RUN);
        fault_n = (st == SV_RUN);
    end

endmodule

// File: rtl/gd_leg_lock.sv
// One half-bridge leg: first-come interlock, dead time, high-side supply hold.
module gd_leg_lock
    import gd_pkg::*;
#(
    parameter int DEAD_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic in_hi,
    input  logic in_lo,
    input  logic hs_rise,
    input  logic hs_fall,
    output logic out_hi,
    output logic out_lo
);
    localparam int DW = $clog2(DEAD_CYC + 1);
    localparam logic [DW-1:0] DEAD_LAST = DW'(DEAD_CYC - 1);

    leg_state_e    st, st_nx;
    logic [DW-1:0] dcnt;
    logic          prev_hi, prev_lo;
    logic          arm_hi, arm_lo;
    logic          hs_ok;
    logic          rise_hi, rise_lo;

    always_comb begin
        rise_hi = in_hi && !prev_hi;
        rise_lo = in_lo && !prev_lo;
    end

    // edge history, arming and high-side supply hysteresis
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_hi <= 1'b0;
            prev_lo <= 1'b0;
            arm_hi  <= 1'b0;
            arm_lo  <= 1'b0;
            hs_ok   <= 1'b0;
        end else begin
            prev_hi <= in_hi;
            prev_lo <= in_lo;
            arm_hi  <= en && hs_ok && in_hi && (arm_hi || (rise_hi && !in_lo));
            arm_lo  <= en && in_lo && (arm_lo || (rise_lo && !in_hi));
            if (hs_fall) begin
                hs_ok <= 1'b0;
            end else if (hs_rise) begin
                hs_ok <= 1'b1;
            end
        end
    end

    // next-state logic
    always_comb begin
        st_nx = st;
        unique case (st)
            LG_IDLE: begin
                if (en && hs_ok && arm_hi && in_hi) begin
                    st_nx = LG_HIGH;
                end else if (en && arm_lo && in_lo) begin
                    st_nx = LG_LOW;
                end
            end
            LG_HIGH: if (!(en && hs_ok && in_hi)) st_nx = LG_DEAD;
            LG_LOW:  if (!(en && in_lo))          st_nx = LG_DEAD;
            LG_DEAD: if (dcnt == DEAD_LAST)       st_nx = LG_IDLE;
        endcase
    end

    // state register and dead-time counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st   <= LG_IDLE;
            dcnt <= '0;
        end else begin
            st   <= st_nx;
            dcnt <= (st == LG_DEAD && st_nx == LG_DEAD) ? dcnt + 1'b1 : '0;
        end
    end

    // outputs
    always_comb begin
        out_hi = (st == LG_HIGH) && en && hs_ok;
        out_lo = (st == LG_LOW) && en;
    end

endmodule

// File: rtl/gate_guard.sv
module gate_guard #(
    parameter int NLEG      = 3,
    parameter int DEAD_CYC  = 4,
    parameter int FILT_CYC  = 6,
    parameter int CLEAR_CYC = 50,
    parameter int SHUT_CYC  = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLEG-1:0] pwm_hi,
    input  logic [NLEG-1:0] pwm_lo,
    input  logic            oc_flag,
    input  logic            vdd_ok_rise,
    input  logic            vdd_low_fall,
    input  logic [NLEG-1:0] hs_ok_rise,
    input  logic [NLEG-1:0] hs_low_fall,
    output logic [NLEG-1:0] gate_hi,
    output logic [NLEG-1:0] gate_lo,
    output logic            fault_n
);
    // filter window capped so that shutdown stays within SHUT_CYC samples (R7)
    localparam int FILT_EFF = (FILT_CYC < SHUT_CYC) ? FILT_CYC : SHUT_CYC;

    logic trip;
    logic run;

    gd_oc_filter #(.FILT_CYC(FILT_EFF)) u_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .oc_raw (oc_flag),
        .trip   (trip)
    );

    gd_supervisor #(.CLEAR_CYC(CLEAR_CYC)) u_sup (
        .clk      (clk),
        .rst_n    (rst_n),
        .trip     (trip),
        .oc_raw   (oc_flag),
        .vdd_rise (vdd_ok_rise),
        .vdd_fall (vdd_low_fall),
        .run      (run),
        .fault_n  (fault_n)
    );

    for (genvar g = 0; g < NLEG; g++) begin : g_leg
        gd_leg_lock #(.DEAD_CYC(DEAD_CYC)) u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (run),
            .in_hi   (pwm_hi[g]),
            .in_lo   (pwm_lo[g]),
            .hs_rise (hs_ok_rise[g]),
            .hs_fall (hs_low_fall[g]),
            .out_hi  (gate_hi[g]),
            .out_lo  (gate_lo[g])
        );
    end

endmodule

// File: rtl/gate_guard_chk.sv
module gate_guard_chk #(
    parameter int NLEG     = 3,
    parameter int DEAD_CYC = 4,
    parameter int SHUT_CYC = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            oc_flag,
    input logic            vdd_low_fall,
    input logic [NLEG-1:0] hs_low_fall,
    input logic [NLEG-1:0] gate_hi,
    input logic [NLEG-1:0] gate_lo,
    input logic            fault_n
);
    localparam int SW = $clog2(SHUT_CYC + 1);
    localparam int OW = $clog2(DEAD_CYC + 1);

    logic [SW-1:0] oc_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oc_run <= '0;
        end else if (!oc_flag) begin
            oc_run <= '0;
        end else if (oc_run != SW'(SHUT_CYC)) begin
            oc_run <= oc_run + 1'b1;
        end
    end

    // R1: legs never cross-conduct
    p_leg_exclusive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_hi & gate_lo) == '0);

    // R7: over-current held SHUT_CYC samples implies everything is off
    p_oc_shutdown_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_run == SW'(SHUT_CYC)) |-> (gate_hi == '0 && gate_lo == '0 && !fault_n));

    // R10: fault release never coincides with an active gate
    p_rearm_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault_n) |-> (gate_hi == '0 && gate_lo == '0));

    // R11: supply-fall flag removes gates and raises the fault next edge
    p_supply_fall_r11: assert property (@(posedge clk) disable iff (!rst_n)
        vdd_low_fall |=> (!fault_n && gate_hi == '0 && gate_lo == '0));

    for (genvar g = 0; g < NLEG; g++) begin : g_chk
        logic [OW-1:0] off_run;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                off_run <= '0;
            end else if (gate_hi[g] || gate_lo[g]) begin
                off_run <= '0;
            end else if (off_run != OW'(DEAD_CYC)) begin
                off_run <= off_run + 1'b1;
            end
        end

        // R5: any turn-on is preceded by at least DEAD_CYC off cycles
        p_dead_gap_r5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(gate_hi[g] || gate_lo[g]) |-> (off_run == OW'(DEAD_CYC)));

        // R12: high-side supply loss drops that leg's high gate
        p_hs_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
            hs_low_fall[g] |=> !gate_hi[g]);
    end

endmodule

bind gate_guard gate_guard_chk #(
    .NLEG     (NLEG),
    .DEAD_CYC (DEAD_CYC),
    .SHUT_CYC (SHUT_CYC)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .oc_flag      (oc_flag),
    .vdd_low_fall (vdd_low_fall),
    .hs_low_fall  (hs_low_fall),
    .gate_hi      (gate_hi),
    .gate_lo      (gate_lo),
    .fault_n      (fault_n)
);

// File: tb/gate_guard_tb.sv
module gate_guard_tb;
    localparam int CLK_P = 10;
    localparam int NLEG  = 3;
    localparam int DEAD  = 4;
    localparam int FILT  = 6;
    localparam int CLR   = 50;
    localparam int SHUT  = 8;
    localparam int LIMIT = 5000;

    typedef struct {
        int         cyc;
        logic [2:0] hi;
        logic [2:0] lo;
        logic       fn;
        string      tag;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NLEG-1:0] pwm_hi = '0;
    logic [NLEG-1:0] pwm_lo = '0;
    logic            oc_flag = 1'b0;
    logic            vdd_ok_rise = 1'b0;
    logic            vdd_low_fall = 1'b0;
    logic [NLEG-1:0] hs_ok_rise = '0;
    logic [NLEG-1:0] hs_low_fall = '0;
    logic [NLEG-1:0] gate_hi;
    logic [NLEG-1:0] gate_lo;
    logic            fault_n;

    int   cyc = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;
    exp_t q[$];

    always #(CLK_P/2) clk = ~clk;

    gate_guard #(
        .NLEG(NLEG), .DEAD_CYC(DEAD), .FILT_CYC(FILT),
        .CLEAR_CYC(CLR), .SHUT_CYC(SHUT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_hi(pwm_hi), .pwm_lo(pwm_lo),
        .oc_flag(oc_flag), .vdd_ok_rise(vdd_ok_rise), .vdd_low_fall(vdd_low_fall),
        .hs_ok_rise(hs_ok_rise), .hs_low_fall(hs_low_fall),
        .gate_hi(gate_hi), .gate_lo(gate_lo), .fault_n(fault_n)
    );

    // monitor: pops due expectations a quarter period after each edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            cyc++;
            #(CLK_P/4);
            while (q.size() > 0 && q[0].cyc <= cyc) begin
                e = q.pop_front();
                n_chk++;
                if (e.cyc != cyc || gate_hi !== e.hi || gate_lo !== e.lo || fault_n !== e.fn) begin
                    n_fail++;
                    $display("FAIL %s: cyc %0d got hi=%b lo=%b fn=%b, expected (cyc %0d) hi=%b lo=%b fn=%b",
                             e.tag, cyc, gate_hi, gate_lo, fault_n, e.cyc, e.hi, e.lo, e.fn);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: cyc %0d got hung run, expected completion", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic at_neg(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input int ahead, input logic [2:0] h, input logic [2:0] l,
                              input logic f, input string tag);
        exp_t e;
        e.cyc = cyc + ahead;
        e.hi  = h;
        e.lo  = l;
        e.fn  = f;
        e.tag = tag;
        q.push_back(e);
    endtask

    initial begin
        // reset
        at_neg(1);
        pwm_hi = '1;
        expect_out(1, 3'b000, 3'b000, 1'b0, "R13 outputs off in reset");
        at_neg(2);
        rst_n = 1'b1;
        expect_out(2, 3'b000, 3'b000, 1'b0, "R13 fault held until supply rise");
        at_neg(3);
        pwm_hi = '0;
        at_neg(1);

        // enable supplies
        hs_ok_rise  = '1;
        vdd_ok_rise = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R11 rising flag enables");
        at_neg(1);
        hs_ok_rise  = '0;
        vdd_ok_rise = 1'b0;
        at_neg(2);

        // basic grant, then late low command blocked
        pwm_hi[0] = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R2 not yet granted");
        expect_out(2, 3'b001, 3'b000, 1'b1, "R2 high granted");
        at_neg(3);
        pwm_lo[0] = 1'b1;
        expect_out(3, 3'b001, 3'b000, 1'b1, "R1 R3 late low blocked");
        at_neg(4);
        pwm_hi[0] = 1'b0;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R2 high released");
        expect_out(DEAD + 4, 3'b000, 3'b000, 1'b1, "R3 late low never passes");
        at_neg(DEAD + 6);
        pwm_lo[0] = 1'b0;
        at_neg(2);

        // complementary swap with dead time on leg 1
        pwm_hi[1] = 1'b1;
        expect_out(2, 3'b010, 3'b000, 1'b1, "R2 leg1 high");
        at_neg(3);
        pwm_hi[1] = 1'b0;
        pwm_lo[1] = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R5 both off after release");
        expect_out(DEAD + 1, 3'b000, 3'b000, 1'b1, "R5 still in dead time");
        expect_out(DEAD + 2, 3'b000, 3'b010, 1'b1, "R5 low after dead time");
        at_neg(DEAD + 4);
        pwm_lo[1] = 1'b0;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R2 low released");
        at_neg(DEAD + 3);

        // simultaneous rise on leg 2
        pwm_hi[2] = 1'b1;
        pwm_lo[2] = 1'b1;
        expect_out(2, 3'b000, 3'b000, 1'b1, "R4 simultaneous rise blocked");
        expect_out(6, 3'b000, 3'b000, 1'b1, "R4 still blocked");
        at_neg(7);
        pwm_hi[2] = 1'b0;
        pwm_lo[2] = 1'b0;
        at_neg(2);

        // high-side supply loss on leg 2
        hs_low_fall[2] = 1'b1;
        at_neg(1);
        hs_low_fall[2] = 1'b0;
        pwm_hi[2] = 1'b1;
        expect_out(2, 3'b000, 3'b000, 1'b1, "R12 high held off");
        expect_out(5, 3'b000, 3'b000, 1'b1, "R12 high still held off");
        at_neg(6);
        pwm_hi[2] = 1'b0;
        at_neg(1);
        pwm_lo[2] = 1'b1;
        expect_out(2, 3'b000, 3'b100, 1'b1, "R12 low side unaffected");
        at_neg(3);
        pwm_lo[2] = 1'b0;
        at_neg(DEAD + 3);
        hs_ok_rise[2] = 1'b1;
        at_neg(1);
        hs_ok_rise[2] = 1'b0;
        pwm_hi[2] = 1'b1;
        expect_out(2, 3'b100, 3'b000, 1'b1, "R12 high after rising flag");
        at_neg(3);
        hs_low_fall[2] = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R12 high dropped on falling flag");
        at_neg(1);
        hs_low_fall[2] = 1'b0;
        pwm_hi[2] = 1'b0;
        at_neg(DEAD + 3);
        hs_ok_rise[2] = 1'b1;
        at_neg(1);
        hs_ok_rise[2] = 1'b0;
        at_neg(1);

        // over-current glitch
        pwm_hi[0] = 1'b1;
        at_neg(3);
        oc_flag = 1'b1;
        at_neg(FILT - 1);
        oc_flag = 1'b0;
        expect_out(3, 3'b001, 3'b000, 1'b1, "R6 short over-current ignored");
        at_neg(4);

        // qualified trip with clean clear
        oc_flag = 1'b1;
        expect_out(FILT - 1, 3'b001, 3'b000, 1'b1, "R7 still on before filter");
        expect_out(FILT, 3'b000, 3'b000, 1'b0, "R7 shutdown on filtered trip");
        at_neg(FILT + 2);
        oc_flag = 1'b0;
        expect_out(CLR - 3, 3'b000, 3'b000, 1'b0, "R8 clear timer running");
        expect_out(CLR - 2, 3'b000, 3'b000, 1'b1, "R8 resume after clear time");
        expect_out(CLR + 3, 3'b000, 3'b000, 1'b1, "R10 held command not passed");
        at_neg(CLR + 4);
        pwm_hi[0] = 1'b0;
        at_neg(2);
        pwm_hi[0] = 1'b1;
        expect_out(2, 3'b001, 3'b000, 1'b1, "R10 re-asserted command passes");
        at_neg(3);

        // trip with over-current persisting past the clear time
        oc_flag = 1'b1;
        expect_out(FILT, 3'b000, 3'b000, 1'b0, "R9 trip");
        expect_out(FILT + CLR + 2, 3'b000, 3'b000, 1'b0, "R9 fault held while flag high");
        at_neg(FILT + CLR + 3);
        oc_flag = 1'b0;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R9 resume after flag low");
        at_neg(2);
        pwm_hi[0] = 1'b0;
        at_neg(2);

        // logic supply undervoltage with hysteresis
        pwm_lo[1] = 1'b1;
        expect_out(2, 3'b000, 3'b010, 1'b1, "R2 leg1 low");
        at_neg(3);
        vdd_low_fall = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b0, "R11 falling flag shuts down");
        at_neg(1);
        vdd_low_fall = 1'b0;
        expect_out(5, 3'b000, 3'b000, 1'b0, "R11 fault held by hysteresis");
        at_neg(6);
        vdd_ok_rise = 1'b1;
        expect_out(1, 3'b000, 3'b000, 1'b1, "R11 rising flag releases fault");
        at_neg(1);
        vdd_ok_rise = 1'b0;
        pwm_lo[1] = 1'b0;
        at_neg(4);

        done = 1'b1;
        if (q.size() != 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending items, expected 0", q.size());
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule